// File: doc/BRIEF.md
# Transmit DMA Channel Register Block

This block is the host-visible control and state-tracking front of a multichannel transmit DMA engine. A host reaches it through a simple 32-bit register bus with separate read and write strobes. It holds a table of sixteen descriptor-ring base pointers. For each of eight channels it holds a configuration word, a credit word and a buffer-status word, and it runs a small enable state machine per channel.

Each channel's state machine has three operating modes. Normal operation lets the channel raise its request line. A stop mode drops requests at once. A drain mode lets the frame in flight finish and stops the channel when the engine signals the end of that frame. The request line also needs the channel's internal-request enable bit and the engine's data-available input.

The fetch and move datapath sits outside this block. It supplies per-channel data-available and frame-end pulses, and per-channel "buffers empty" and "no pending request" flags. The block packs those two flag vectors into one shared status word. The host polls that word after stopping a channel, and a channel counts as idle only when both of its bits are set.

Top module: `txdma_regs`

## Requirements
- R1: Sixteen ring base pointer registers sit at byte address 0x000 + 4*q for q in 0..15. Bits 27:0 are read/write and hold address bits 35:8 of a 256-byte-aligned ring. Bits 31:28 read as zero. The table powers up as zero and is not cleared by reset.
- R2: Channel c (0..7) has its configuration word at 0x100 + 0x20*c, its credit word at that address + 0x4 and its buffer-status word at + 0x8. The credit and buffer-status words are full 32-bit read/write. Buffer-status codes written by the host (0x0 empty, 0x2000 waiting, 0x3 valid) read back unchanged.
- R3: In the configuration word, bits 31:30 hold the mode: 00 stop, 01 drain, 10 normal, and 11 behaves as stop. Bit 3 is the internal-request enable. These three bits read back as written, and every other bit reads as zero.
- R4: A read strobe in cycle t gives bus_rvalid and bus_rdata in cycle t+1. Reads from an address outside R1, R2 and R9 return zero. Writes to such an address change nothing.
- R5: ch_req[c] is registered. It is high only while channel c is in normal or drain state, its bit 3 is set and ch_avail[c] was high at the previous edge.
- R6: Writing mode 00 or 11 forces ch_req[c] low in the cycle after the write, whatever ch_avail[c] is.
- R7: Writing mode 01 to a running channel keeps its requests going until a ch_frame_end[c] pulse. ch_req[c] is low from the cycle after that pulse and stays low until mode 10 is written again.
- R8: A frame-end pulse in the same cycle as a mode 01 write stops the channel at once. Mode 01 written to a stopped channel leaves it stopped. A frame-end pulse in normal mode has no effect.
- R9: The shared status word at 0x200 carries ch_bufs_empty[7:0] in bits 31:24 and ch_no_pend[7:0] in bits 23:16, sampled in the read cycle. All other bits are zero.
- R10: While reset is high and in the cycle after it, ch_req and bus_rvalid are zero. Channel registers come out of reset as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ch_avail | input | 8 | Per-channel data available from the engine |
| ch_frame_end | input | 8 | Per-channel end-of-frame pulse |
| ch_bufs_empty | input | 8 | Per-channel buffers empty flag |
| ch_no_pend | input | 8 | Per-channel no pending request flag |
| ch_req | output | 8 | Per-channel internal DMA request |

## Verification
The collision that matters is a host write to a channel's configuration word that lands in the same cycle as that channel's frame-end pulse. The bench raises ch_frame_end and issues a drain-mode write on the same falling edge, so both are sampled at one rising edge. It then requires the request line to be low one cycle later, with no drain phase in between. The bench also pulses frame-end against a channel in normal mode and against a channel draining with no write, and it reads the configuration back through the bus, so that each input combination is judged on its own.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_DRAIN = 2'd2
  } ch_state_e;

  localparam logic [1:0] MODE_STOP = 2'b00;
  localparam logic [1:0] MODE_EOF  = 2'b01;
  localparam logic [1:0] MODE_RUN  = 2'b10;

  localparam int MODE_HI  = 31;
  localparam int MODE_LO  = 30;
  localparam int DREQ_BIT = 3;

endpackage

// File: rtl/txdma_qtable.sv
module txdma_qtable #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 28,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [IW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/txdma_chan.sv
module txdma_chan
  import txdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cred_we,
  input  logic          bsts_we,
  input  logic [DW-1:0] wdata,
  input  logic          avail,
  input  logic          frame_end,
  output logic [DW-1:0] cfg_rd,
  output logic [DW-1:0] cred_rd,
  output logic [DW-1:0] bsts_rd,
  output logic          req
);

  logic [1:0]    mode_q, mode_n;
  logic          en_q, en_n;
  logic [DW-1:0] cred_q, bsts_q;
  ch_state_e     state_q, state_n;
  logic          req_q, req_n;

  always_comb begin
    mode_n = cfg_we ? wdata[MODE_HI:MODE_LO] : mode_q;
    en_n   = cfg_we ? wdata[DREQ_BIT] : en_q;
    case (mode_n)
      MODE_RUN: state_n = CH_RUN;
      MODE_EOF: state_n = (state_q == CH_IDLE || frame_end) ? CH_IDLE : CH_DRAIN;
      default:  state_n = CH_IDLE;
    endcase
    req_n = (state_n != CH_IDLE) && en_n && avail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_STOP;
      en_q    <= 1'b0;
      cred_q  <= '0;
      bsts_q  <= '0;
      state_q <= CH_IDLE;
      req_q   <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      en_q    <= en_n;
      state_q <= state_n;
      req_q   <= req_n;
      if (cred_we) cred_q <= wdata;
      if (bsts_we) bsts_q <= wdata;
    end
  end

  always_comb begin
    cfg_rd                  = '0;
    cfg_rd[MODE_HI:MODE_LO] = mode_q;
    cfg_rd[DREQ_BIT]        = en_q;
  end
  assign cred_rd = cred_q;
  assign bsts_rd = bsts_q;
  assign req     = req_q;

  assert_req_qualified_R5: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (en_q && state_q != CH_IDLE));

  assert_stop_drops_req_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && wdata[MODE_HI:MODE_LO] != MODE_RUN && wdata[MODE_HI:MODE_LO] != MODE_EOF)
      |=> !req_q);

  assert_eof_stops_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == CH_DRAIN && frame_end && !cfg_we) |=> (state_q == CH_IDLE && !req_q));

  assert_idle_stays_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == CH_IDLE && !cfg_we) |=> (state_q == CH_IDLE && !req_q));

endmodule

// File: rtl/txdma_regs.sv
module txdma_regs #(
  parameter int NUM_CH    = 8,
  parameter int NUM_Q     = 16,
  parameter int AW        = 12,
  parameter int DW        = 32,
  parameter int QPTR_W    = 28,
  parameter int QBASE     = 'h000,
  parameter int CHBASE    = 'h100,
  parameter int CH_STRIDE = 32,
  parameter int STAT_ADDR = 'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  input  logic [NUM_CH-1:0] ch_avail,
  input  logic [NUM_CH-1:0] ch_frame_end,
  input  logic [NUM_CH-1:0] ch_bufs_empty,
  input  logic [NUM_CH-1:0] ch_no_pend,
  output logic [NUM_CH-1:0] ch_req
);

  localparam int QIW = $clog2(NUM_Q);
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SW  = $clog2(CH_STRIDE);
  localparam logic [AW-1:0] QBASE_A  = AW'(QBASE);
  localparam logic [AW-1:0] QSPAN_A  = AW'(NUM_Q * 4);
  localparam logic [AW-1:0] CHBASE_A = AW'(CHBASE);
  localparam logic [AW-1:0] CHSPAN_A = AW'(NUM_CH * CH_STRIDE);
  localparam logic [AW-1:0] STAT_A   = AW'(STAT_ADDR);

  // decode
  logic [AW-1:0]   q_off, ch_off;
  logic            q_hit, ch_hit, stat_hit, chreg_ok;
  logic [QIW-1:0]  q_idx;
  logic [CHW-1:0]  ch_idx;
  logic [SW-3:0]   rsel;

  always_comb begin
    q_off    = bus_addr - QBASE_A;
    ch_off   = bus_addr - CHBASE_A;
    q_hit    = q_off < QSPAN_A;
    ch_hit   = ch_off < CHSPAN_A;
    stat_hit = bus_addr[AW-1:2] == STAT_A[AW-1:2];
    q_idx    = q_off[QIW+1:2];
    ch_idx   = ch_off[SW +: CHW];
    rsel     = ch_off[SW-1:2];
    chreg_ok = ch_hit && rsel < 3;
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^{q_off[1:0], ch_off[1:0]};

  // queue base pointer table
  logic [QPTR_W-1:0] qt_rdata;

  txdma_qtable #(.DEPTH(NUM_Q), .WIDTH(QPTR_W)) u_qtable (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_wr && q_hit),
    .waddr (q_idx),
    .wdata (bus_wdata[QPTR_W-1:0]),
    .re    (bus_rd && q_hit),
    .raddr (q_idx),
    .rdata (qt_rdata)
  );

  // channels
  logic [DW-1:0] cfg_rd  [NUM_CH];
  logic [DW-1:0] cred_rd [NUM_CH];
  logic [DW-1:0] bsts_rd [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_c;
    assign sel_c = bus_wr && ch_hit && (ch_idx == CHW'(c));

    txdma_chan #(.DW(DW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (sel_c && rsel == 0),
      .cred_we   (sel_c && rsel == 1),
      .bsts_we   (sel_c && rsel == 2),
      .wdata     (bus_wdata),
      .avail     (ch_avail[c]),
      .frame_end (ch_frame_end[c]),
      .cfg_rd    (cfg_rd[c]),
      .cred_rd   (cred_rd[c]),
      .bsts_rd   (bsts_rd[c]),
      .req       (ch_req[c])
    );
  end

  // shared status word
  logic [DW-1:0] stat_word;
  always_comb begin
    stat_word = '0;
    stat_word[24 +: NUM_CH] = ch_bufs_empty;
    stat_word[16 +: NUM_CH] = ch_no_pend;
  end

  // read path
  logic [DW-1:0] reg_rdata_q;
  logic          q_sel_q, rvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_q <= '0;
      q_sel_q     <= 1'b0;
      rvalid_q    <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      q_sel_q  <= bus_rd && q_hit;
      if (bus_rd) begin
        if (chreg_ok) begin
          case (rsel)
            0:       reg_rdata_q <= cfg_rd[ch_idx];
            1:       reg_rdata_q <= cred_rd[ch_idx];
            default: reg_rdata_q <= bsts_rd[ch_idx];
          endcase
        end else if (stat_hit) begin
          reg_rdata_q <= stat_word;
        end else begin
          reg_rdata_q <= '0;
        end
      end
    end
  end

  assign bus_rdata  = q_sel_q ? {{(DW-QPTR_W){1'b0}}, qt_rdata} : reg_rdata_q;
  assign bus_rvalid = rvalid_q;

  assert_rvalid_follows_rd_R4: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  assert_unmapped_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !q_hit && !chreg_ok && !stat_hit) |=> (bus_rdata == '0));

  assert_qptr_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && q_hit) |=> (bus_rdata[DW-1:QPTR_W] == '0));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!bus_rvalid && ch_req == '0));

endmodule

// File: tb/txdma_regs_bench.sv
`timescale 1ns/1ps
module txdma_regs_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  ch_avail = '0, ch_frame_end = '0;
  logic [7:0]  ch_bufs_empty = 8'hA5, ch_no_pend = 8'h3C;
  logic [7:0]  ch_req;

  always #2.5 clk = ~clk;

  txdma_regs u_txdma_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ch_avail(ch_avail), .ch_frame_end(ch_frame_end), .ch_bufs_empty(ch_bufs_empty),
    .ch_no_pend(ch_no_pend), .ch_req(ch_req)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [11:0] cfg_a(int c);  return 12'(12'h100 + c * 32); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver tasks, called on a falling edge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: compare read results against the scoreboard
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R4 unexpected rvalid actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R10 req in reset", {24'b0, ch_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 req after reset", {24'b0, ch_req}, 32'h0);
    check("R10 rvalid after reset", {31'b0, bus_rvalid}, 32'h0);
    rd(cfg_a(0), 32'h0, "R10 cfg0 reset value");
    rd(12'h200, 32'hA53C0000, "R9 status word");

    // R1 queue pointer table
    wr(12'h000, 32'hFFFFFFFF);
    wr(12'h03C, 32'h12345678);
    rd(12'h000, 32'h0FFFFFFF, "R1 q0 upper bits zero");
    rd(12'h03C, 32'h02345678, "R1 q15");
    rd(12'h01C, 32'h0, "R1 q7 untouched");

    // R2 credit and buffer-status words
    wr(cfg_a(3) + 12'h4, 32'hDEADBEEF);
    wr(cfg_a(7) + 12'h8, 32'h00002000);
    wr(cfg_a(0) + 12'h8, 32'h00000003);
    rd(cfg_a(3) + 12'h4, 32'hDEADBEEF, "R2 credit ch3");
    rd(cfg_a(7) + 12'h8, 32'h00002000, "R2 bufsts ch7 waiting");
    rd(cfg_a(0) + 12'h8, 32'h00000003, "R2 bufsts ch0 valid");
    rd(cfg_a(4) + 12'h4, 32'h0, "R2 credit ch4 untouched");

    // R3 reserved bits, mode 11 acts as stop
    ch_avail[2] = 1'b1;
    wr(cfg_a(2), 32'hFFFFFFFF);
    check("R3 mode 11 no req", {31'b0, ch_req[2]}, 32'h0);
    rd(cfg_a(2), 32'hC0000008, "R3 cfg readback masked");

    // R4 unmapped space
    wr(12'h044, 32'hFFFFFFFF);
    wr(cfg_a(1) + 12'hC, 32'hFFFFFFFF);
    rd(12'h044, 32'h0, "R4 gap after queue table");
    rd(cfg_a(1) + 12'hC, 32'h0, "R4 channel hole");
    rd(12'h300, 32'h0, "R4 high unmapped");
    rd(cfg_a(1), 32'h0, "R4 hole write left cfg1 alone");

    // R5 request qualification
    wr(cfg_a(1), 32'h80000008);
    check("R5 no req without avail", {31'b0, ch_req[1]}, 32'h0);
    ch_avail[1] = 1'b1;
    @(negedge clk);
    check("R5 req with avail", {31'b0, ch_req[1]}, 32'h1);
    ch_avail[4] = 1'b1;
    wr(cfg_a(4), 32'h80000000);
    check("R5 no req without enable bit", {31'b0, ch_req[4]}, 32'h0);

    // R6 stop
    wr(cfg_a(1), 32'h00000008);
    check("R6 stop drops req", {31'b0, ch_req[1]}, 32'h0);

    // R7 drain at end of frame
    wr(cfg_a(1), 32'h80000008);
    check("R7 running", {31'b0, ch_req[1]}, 32'h1);
    wr(cfg_a(1), 32'h40000008);
    check("R7 drain keeps req", {31'b0, ch_req[1]}, 32'h1);
    repeat (3) @(negedge clk);
    check("R7 drain still req", {31'b0, ch_req[1]}, 32'h1);
    ch_frame_end[1] = 1'b1;
    @(negedge clk);
    ch_frame_end[1] = 1'b0;
    check("R7 stop after frame end", {31'b0, ch_req[1]}, 32'h0);
    repeat (2) @(negedge clk);
    check("R7 stays stopped", {31'b0, ch_req[1]}, 32'h0);
    rd(cfg_a(1), 32'h40000008, "R7 cfg reads drain mode");
    wr(cfg_a(1), 32'h80000008);
    check("R7 restart by normal mode", {31'b0, ch_req[1]}, 32'h1);

    // R8 same-cycle frame end and drain write
    ch_frame_end[1] = 1'b1;
    wr(cfg_a(1), 32'h40000008);
    ch_frame_end[1] = 1'b0;
    check("R8 collision stops at once", {31'b0, ch_req[1]}, 32'h0);
    ch_avail[5] = 1'b1;
    wr(cfg_a(5), 32'h40000008);
    check("R8 drain on stopped channel", {31'b0, ch_req[5]}, 32'h0);
    wr(cfg_a(1), 32'h80000008);
    ch_frame_end[1] = 1'b1;
    @(negedge clk);
    ch_frame_end[1] = 1'b0;
    check("R8 frame end ignored in normal", {31'b0, ch_req[1]}, 32'h1);

    // R9 status word tracks inputs
    ch_bufs_empty = 8'h0F; ch_no_pend = 8'hF1;
    rd(12'h200, 32'h0FF10000, "R9 status word updated");

    repeat (2) @(negedge clk);
    check("R4 all reads returned", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule